// File: doc/BRIEF.md
# Power-Up Loaded Configuration Register File

This block is the byte-wide register file that sits behind a serial register interface. Its host side is a simple bus: a 7-bit address, write data, a write strobe and a read strobe, with read data returned one clock after the read strobe. Sixteen configuration bytes drive the chip's settings directly through a flat output vector. They live in a writable shadow store. When reset is released, the store is filled from a one-time-programmable array, which is modelled here as a parameterised input vector.

The copy is run by a two-state sequencer. In state `ST_COPY` it moves one byte per cycle in ascending order and holds `busy` high. On its last index it takes the transition *copy done* to `ST_READY`. It stays in `ST_READY` (transition *hold*) until the next reset. Every reset returns the sequencer to `ST_COPY` (transition *restart*).

Outside the shadow store, the file provides the following:

- a read-only mirror of the programmed array;
- a constant profile identifier;
- an eight-byte identification bank, which the host can write.

One bit of the shadow store locks the whole writable area against writes. The same bit also masks that area on reads.

Top module: `cfg_regfile`

## Requirements
- R1: After reset is released, `busy` is high for exactly 16 clock cycles. In cycle k (k = 0..15) it copies `otp_bits[8k+7:8k]` into configuration byte k. `busy` then falls and stays low until the next reset. During reset, `busy` is 1, `bus_rdata` is 0x00 and `cfg_out` is all zero.
- R2: `cfg_out[8i+7:8i]` always equals the content of configuration address i (0x00..0x0F).
- R3: When `busy` is low and protection is clear, a write to 0x00..0x0F stores `bus_wdata` at that address. The new value is visible on `cfg_out` one cycle after the write strobe.
- R4: While `busy` is high, bus writes to any address have no effect.
- R5: `bus_rdata` loads on a clock edge where `bus_re` is 1 and holds its value otherwise. A read and a write to the same address in one cycle return the value held before the write.
- R6: A read of 0x10..0x1F returns programmed byte (address − 0x10), whatever the protection bit is. Writes there have no effect.
- R7: A read of 0x42 returns 0x2C. Writes there have no effect.
- R8: Addresses 0x78..0x7F are an identification bank that can be read and written. After reset they hold 0x00 at 0x78..0x7C, 0xA5 at 0x7D, 0x3C at 0x7E and 0x96 at 0x7F.
- R9: The protection bit is bit 6 of address 0x05. While it is 1, writes to 0x00..0x0F and 0x78..0x7F are rejected, and reads of those ranges return 0x00. As a result, only a reset can clear the bit.
- R10: Reads of every other address return 0x00. Writes to them have no effect.
- R11: If bit 6 of programmed byte 5 is set, protection is in force as soon as the copy completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; releasing it starts the copy |
| otp_bits | input | 128 | Programmed array, byte i in bits 8i+7:8i |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, registered |
| busy | output | 1 | High while the power-up copy runs |
| cfg_out | output | 128 | Active configuration bytes, byte i in bits 8i+7:8i |

## Verification
Two functions can land in the same cycle:

- A host read and a host write to the same configuration byte. The bench issues both strobes together on address 0x07 and expects the pre-write byte back. A second read must then return the new value.
- The copy sequencer and a host write. The bench drives writes while `busy` is high and expects the programmed bytes to survive.

A behavioural model updated on every clock flags any cycle in which `busy`, `cfg_out` or `bus_rdata` departs from it.

// File: rtl/cfg_regfile_pkg.sv
package cfg_regfile_pkg;

    typedef enum logic [0:0] {
        ST_COPY,
        ST_READY
    } copy_state_e;

    typedef enum logic [2:0] {
        RG_CFG,
        RG_OTP,
        RG_PROFILE,
        RG_ID,
        RG_NONE
    } region_e;

endpackage

// File: rtl/cfg_copy_seq.sv
module cfg_copy_seq
    import cfg_regfile_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             busy,
    output logic             copy_we,
    output logic [IDX_W-1:0] copy_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    copy_state_e      state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COPY;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_COPY: begin
                idx_d = idx_q + 1'b1;
                if (idx_q == LAST_IDX) begin
                    state_d = ST_READY;
                end
            end
            ST_READY: begin
                state_d = ST_READY;
            end
            default: state_d = ST_READY;
        endcase
    end

    // outputs
    always_comb begin
        busy     = 1'b0;
        copy_we  = 1'b0;
        copy_idx = idx_q;
        unique case (state_q)
            ST_COPY: begin
                busy    = 1'b1;
                copy_we = 1'b1;
            end
            ST_READY: begin
                busy    = 1'b0;
                copy_we = 1'b0;
            end
            default: begin
                busy    = 1'b0;
                copy_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec
    import cfg_regfile_pkg::*;
#(
    parameter int ADDR_W       = 7,
    parameter int CFG_DEPTH    = 16,
    parameter int ID_BASE      = 120,
    parameter int ID_DEPTH     = 8,
    parameter int PROFILE_ADDR = 66,
    localparam int IDX_W    = $clog2(CFG_DEPTH),
    localparam int ID_IDX_W = $clog2(ID_DEPTH)
) (
    input  logic [ADDR_W-1:0]   addr,
    output region_e             region,
    output logic [IDX_W-1:0]    cfg_off,
    output logic [ID_IDX_W-1:0] id_off
);

    localparam logic [31:0] OTP_END = 32'(2 * CFG_DEPTH);
    localparam logic [31:0] ID_END  = 32'(ID_BASE + ID_DEPTH);

    logic [31:0] a32;
    assign a32 = 32'(addr);

    always_comb begin
        if (a32 < 32'(CFG_DEPTH)) begin
            region = RG_CFG;
        end else if (a32 < OTP_END) begin
            region = RG_OTP;
        end else if (a32 == 32'(PROFILE_ADDR)) begin
            region = RG_PROFILE;
        end else if (a32 >= 32'(ID_BASE) && a32 < ID_END) begin
            region = RG_ID;
        end else begin
            region = RG_NONE;
        end
    end

    // the mirror window starts at CFG_DEPTH, so the low bits index both areas
    assign cfg_off = addr[IDX_W-1:0];
    assign id_off  = ID_IDX_W'(addr - ADDR_W'(ID_BASE));

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import cfg_regfile_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CFG_DEPTH   = 16,
    parameter int ID_DEPTH    = 8,
    parameter int PROFILE_VAL = 'h2C,
    localparam int IDX_W    = $clog2(CFG_DEPTH),
    localparam int ID_IDX_W = $clog2(ID_DEPTH)
) (
    input  region_e                       region,
    input  logic [IDX_W-1:0]              cfg_off,
    input  logic [ID_IDX_W-1:0]           id_off,
    input  logic                          prot,
    input  logic [CFG_DEPTH*DATA_W-1:0]   shadow_flat,
    input  logic [CFG_DEPTH*DATA_W-1:0]   otp_flat,
    input  logic [ID_DEPTH*DATA_W-1:0]    id_flat,
    output logic [DATA_W-1:0]             rbyte
);

    always_comb begin
        rbyte = '0;
        unique case (region)
            RG_CFG:     rbyte = prot ? '0 : shadow_flat[32'(cfg_off)*DATA_W +: DATA_W];
            RG_OTP:     rbyte = otp_flat[32'(cfg_off)*DATA_W +: DATA_W];
            RG_PROFILE: rbyte = DATA_W'(PROFILE_VAL);
            RG_ID:      rbyte = prot ? '0 : id_flat[32'(id_off)*DATA_W +: DATA_W];
            RG_NONE:    rbyte = '0;
            default:    rbyte = '0;
        endcase
    end

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_regfile_pkg::*;
#(
    parameter int ADDR_W       = 7,
    parameter int DATA_W       = 8,
    parameter int CFG_DEPTH    = 16,
    parameter int ID_BASE      = 120,
    parameter int ID_DEPTH     = 8,
    parameter int PROFILE_ADDR = 66,
    parameter int PROFILE_VAL  = 'h2C,
    parameter int PROT_ADDR    = 5,
    parameter int PROT_BIT     = 6,
    parameter logic [ID_DEPTH*DATA_W-1:0] ID_INIT = 64'h963C_A500_0000_0000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CFG_DEPTH*DATA_W-1:0] otp_bits,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    input  logic                        bus_we,
    input  logic                        bus_re,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic                        busy,
    output logic [CFG_DEPTH*DATA_W-1:0] cfg_out
);

    localparam int IDX_W    = $clog2(CFG_DEPTH);
    localparam int ID_IDX_W = $clog2(ID_DEPTH);

    logic [DATA_W-1:0] shadow_q [CFG_DEPTH];
    logic [DATA_W-1:0] id_q     [ID_DEPTH];
    logic [ID_DEPTH*DATA_W-1:0] id_flat;

    logic                copy_we;
    logic [IDX_W-1:0]    copy_idx;
    region_e             region;
    logic [IDX_W-1:0]    cfg_off;
    logic [ID_IDX_W-1:0] id_off;
    logic                prot;
    logic                wr_ok;
    logic [DATA_W-1:0]   rbyte;

    cfg_copy_seq #(.DEPTH(CFG_DEPTH)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .copy_we  (copy_we),
        .copy_idx (copy_idx)
    );

    cfg_addr_dec #(
        .ADDR_W       (ADDR_W),
        .CFG_DEPTH    (CFG_DEPTH),
        .ID_BASE      (ID_BASE),
        .ID_DEPTH     (ID_DEPTH),
        .PROFILE_ADDR (PROFILE_ADDR)
    ) u_dec (
        .addr    (bus_addr),
        .region  (region),
        .cfg_off (cfg_off),
        .id_off  (id_off)
    );

    genvar gi;
    generate
        for (gi = 0; gi < CFG_DEPTH; gi++) begin : g_cfg_flat
            assign cfg_out[gi*DATA_W +: DATA_W] = shadow_q[gi];
        end
        for (gi = 0; gi < ID_DEPTH; gi++) begin : g_id_flat
            assign id_flat[gi*DATA_W +: DATA_W] = id_q[gi];
        end
    endgenerate

    assign prot  = shadow_q[PROT_ADDR][PROT_BIT];
    assign wr_ok = bus_we && !busy && !prot;

    // storage: the copy owns the shadow bytes while it runs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CFG_DEPTH; i++) begin
                shadow_q[i] <= '0;
            end
            for (int i = 0; i < ID_DEPTH; i++) begin
                id_q[i] <= ID_INIT[i*DATA_W +: DATA_W];
            end
        end else if (copy_we) begin
            shadow_q[copy_idx] <= otp_bits[32'(copy_idx)*DATA_W +: DATA_W];
        end else if (wr_ok) begin
            if (region == RG_CFG) begin
                shadow_q[cfg_off] <= bus_wdata;
            end else if (region == RG_ID) begin
                id_q[id_off] <= bus_wdata;
            end
        end
    end

    cfg_read_mux #(
        .DATA_W      (DATA_W),
        .CFG_DEPTH   (CFG_DEPTH),
        .ID_DEPTH    (ID_DEPTH),
        .PROFILE_VAL (PROFILE_VAL)
    ) u_rmux (
        .region      (region),
        .cfg_off     (cfg_off),
        .id_off      (id_off),
        .prot        (prot),
        .shadow_flat (cfg_out),
        .otp_flat    (otp_bits),
        .id_flat     (id_flat),
        .rbyte       (rbyte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            bus_rdata <= rbyte;
        end
    end

endmodule

// File: rtl/cfg_regfile_chk.sv
module cfg_regfile_chk #(
    parameter int ADDR_W       = 7,
    parameter int DATA_W       = 8,
    parameter int CFG_DEPTH    = 16,
    parameter int ID_BASE      = 120,
    parameter int PROFILE_ADDR = 66,
    parameter int PROFILE_VAL  = 'h2C,
    parameter int PROT_ADDR    = 5,
    parameter int PROT_BIT     = 6
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [CFG_DEPTH*DATA_W-1:0] otp_bits,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic                        bus_we,
    input logic                        bus_re,
    input logic [DATA_W-1:0]           bus_rdata,
    input logic                        busy,
    input logic [CFG_DEPTH*DATA_W-1:0] cfg_out
);

    localparam int IDX_W = $clog2(CFG_DEPTH);
    localparam int CNT_W = $clog2(CFG_DEPTH + 1) + 1;

    logic [CNT_W-1:0]  busy_cnt;
    logic              prot;
    logic [31:0]       a32;
    logic [DATA_W-1:0] otp_sel;
    logic              in_otp, in_prot_area, in_hole;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    assign prot         = cfg_out[PROT_ADDR*DATA_W + PROT_BIT];
    assign a32          = 32'(bus_addr);
    assign otp_sel      = otp_bits[32'(bus_addr[IDX_W-1:0])*DATA_W +: DATA_W];
    assign in_otp       = a32 >= 32'(CFG_DEPTH) && a32 < 32'(2*CFG_DEPTH);
    assign in_prot_area = a32 < 32'(CFG_DEPTH) || a32 >= 32'(ID_BASE);
    assign in_hole      = a32 >= 32'(2*CFG_DEPTH) && a32 < 32'(ID_BASE)
                          && a32 != 32'(PROFILE_ADDR);

    // R1
    copy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_cnt == CNT_W'(CFG_DEPTH));

    // R1
    busy_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt >= CNT_W'(CFG_DEPTH)) |-> !busy);

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));

    // R6
    otp_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && in_otp) |=> bus_rdata == $past(otp_sel));

    // R7
    profile_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && a32 == 32'(PROFILE_ADDR)) |=> bus_rdata == DATA_W'(PROFILE_VAL));

    // R9
    prot_write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && prot && bus_we) |=> $stable(cfg_out));

    // R9
    prot_read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && prot && in_prot_area) |=> bus_rdata == '0);

    // R10
    hole_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && in_hole) |=> bus_rdata == '0);

endmodule

bind cfg_regfile cfg_regfile_chk #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .CFG_DEPTH    (CFG_DEPTH),
    .ID_BASE      (ID_BASE),
    .PROFILE_ADDR (PROFILE_ADDR),
    .PROFILE_VAL  (PROFILE_VAL),
    .PROT_ADDR    (PROT_ADDR),
    .PROT_BIT     (PROT_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .otp_bits  (otp_bits),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .cfg_out   (cfg_out)
);

// File: tb/cfg_regfile_test.sv
module cfg_regfile_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] otp;
    logic [6:0]   addr = '0;
    logic [7:0]   wdata = '0;
    logic         we = 1'b0;
    logic         re = 1'b0;
    logic [7:0]   rdata;
    logic         busy;
    logic [127:0] cfg_out;

    int  total = 0;
    int  fails = 0;
    bit  done  = 0;

    always #5 clk = ~clk;

    cfg_regfile uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .otp_bits  (otp),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_we    (we),
        .bus_re    (re),
        .bus_rdata (rdata),
        .busy      (busy),
        .cfg_out   (cfg_out)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_cfg [16];
    logic [7:0] m_id  [8];
    logic [7:0] m_rd;
    bit         m_busy;
    int         m_cnt;

    function automatic logic [7:0] exp_otp(int i);
        return 8'(8'h30 + 3 * i);
    endfunction

    function automatic logic [7:0] model_read(int a);
        bit p = m_cfg[5][6];
        if (a < 16)   return p ? 8'h00 : m_cfg[a];
        if (a < 32)   return otp[(a-16)*8 +: 8];
        if (a == 66)  return 8'h2C;
        if (a >= 120) return p ? 8'h00 : m_id[a-120];
        return 8'h00;
    endfunction

    function automatic logic [127:0] model_cfg();
        logic [127:0] v;
        for (int i = 0; i < 16; i++) v[i*8 +: 8] = m_cfg[i];
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1;
            m_cnt  = 0;
            m_rd   = 8'h00;
            for (int i = 0; i < 16; i++) m_cfg[i] = 8'h00;
            for (int i = 0; i < 8; i++)  m_id[i]  = 8'h00;
            m_id[5] = 8'hA5; m_id[6] = 8'h3C; m_id[7] = 8'h96;
        end else begin
            if (re) m_rd = model_read(int'(addr));
            if (m_busy) begin
                m_cfg[m_cnt] = otp[m_cnt*8 +: 8];
                m_cnt++;
                if (m_cnt == 16) m_busy = 0;
            end else if (we && !m_cfg[5][6]) begin
                if (addr < 16) m_cfg[addr] = wdata;
                else if (addr >= 120) m_id[addr-120] = wdata;
            end
        end
    end

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1 busy vs model", 128'(busy), 128'(m_busy));
            check("R2 cfg_out vs model", cfg_out, model_cfg());
            check("R5 rdata vs model", 128'(rdata), 128'(m_rd));
        end
    end

    // ---------------- bus tasks (called at a falling edge) ----------------
    task automatic bus(input logic w, input logic r, input logic [6:0] a, input logic [7:0] d);
        we = w; re = r; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; re = 1'b0;
    endtask

    task automatic rd_chk(string tag, input logic [6:0] a, input logic [7:0] exp);
        bus(1'b0, 1'b1, a, 8'h00);
        check(tag, 128'(rdata), 128'(exp));
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        bus(1'b1, 1'b0, a, d);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        #200000;
        total++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) otp[i*8 +: 8] = exp_otp(i);
        repeat (3) @(negedge clk);
        // reset state R1
        check("R1 reset busy", 128'(busy), 128'(1));
        check("R1 reset rdata", 128'(rdata), 128'(0));
        check("R1 reset cfg_out", cfg_out, 128'(0));
        rst_n = 1'b1;

        // R4: writes during the copy
        wr(7'h03, 8'hFF);
        wr(7'h0F, 8'hEE);
        wr(7'h78, 8'h77);
        begin
            int cyc = 3;
            while (busy) begin @(negedge clk); cyc++; end
            check("R1 copy length", 128'(cyc), 128'(16));
        end
        check("R4 byte3 kept", 128'(cfg_out[31:24]), 128'(exp_otp(3)));
        check("R4 byte15 kept", 128'(cfg_out[127:120]), 128'(exp_otp(15)));
        rd_chk("R4 id 0x78 kept", 7'h78, 8'h00);
        for (int i = 0; i < 16; i++)
            check("R1 copied byte", 128'(cfg_out[i*8 +: 8]), 128'(exp_otp(i)));

        // R3
        wr(7'h02, 8'h5A);
        check("R3 cfg_out byte2", 128'(cfg_out[23:16]), 128'(8'h5A));
        rd_chk("R3 readback 0x02", 7'h02, 8'h5A);
        wr(7'h0F, 8'h81);
        check("R2 cfg_out byte15", 128'(cfg_out[127:120]), 128'(8'h81));

        // R5: read and write in one cycle
        bus(1'b1, 1'b1, 7'h07, 8'hC3);
        check("R5 same-cycle old value", 128'(rdata), 128'(exp_otp(7)));
        repeat (2) @(negedge clk);
        check("R5 rdata holds", 128'(rdata), 128'(exp_otp(7)));
        rd_chk("R5 new value", 7'h07, 8'hC3);

        // R6
        for (int i = 0; i < 16; i++) rd_chk("R6 mirror", 7'(16 + i), exp_otp(i));
        wr(7'h12, 8'h00);
        rd_chk("R6 mirror write ignored", 7'h12, exp_otp(2));

        // R7
        rd_chk("R7 profile id", 7'h42, 8'h2C);
        wr(7'h42, 8'h11);
        rd_chk("R7 profile write ignored", 7'h42, 8'h2C);

        // R8
        rd_chk("R8 id 0x7D", 7'h7D, 8'hA5);
        rd_chk("R8 id 0x7E", 7'h7E, 8'h3C);
        rd_chk("R8 id 0x7F", 7'h7F, 8'h96);
        rd_chk("R8 id 0x7C", 7'h7C, 8'h00);
        wr(7'h79, 8'h6B);
        rd_chk("R8 id write 0x79", 7'h79, 8'h6B);

        // R10
        rd_chk("R10 hole 0x20", 7'h20, 8'h00);
        rd_chk("R10 hole 0x41", 7'h41, 8'h00);
        rd_chk("R10 hole 0x43", 7'h43, 8'h00);
        rd_chk("R10 hole 0x77", 7'h77, 8'h00);
        wr(7'h30, 8'hEE);
        rd_chk("R10 hole write ignored", 7'h30, 8'h00);

        // R9: set protection
        wr(7'h05, exp_otp(5) | 8'h40);
        wr(7'h01, 8'h99);
        check("R9 write blocked byte1", 128'(cfg_out[15:8]), 128'(exp_otp(1)));
        rd_chk("R9 read masked 0x01", 7'h01, 8'h00);
        rd_chk("R9 read masked 0x7D", 7'h7D, 8'h00);
        rd_chk("R9 mirror still readable", 7'h10, exp_otp(0));
        rd_chk("R9 profile still readable", 7'h42, 8'h2C);
        wr(7'h05, 8'h00);
        check("R9 lock not clearable", 128'(cfg_out[47:40]), 128'(exp_otp(5) | 8'h40));

        // R11: protection programmed in the array
        rst_n = 1'b0;
        otp[47:40] = 8'h7F;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        while (busy) @(negedge clk);
        check("R11 prot byte copied", 128'(cfg_out[47:40]), 128'(8'h7F));
        rd_chk("R11 read masked 0x00", 7'h00, 8'h00);
        wr(7'h02, 8'h12);
        check("R11 write blocked", 128'(cfg_out[23:16]), 128'(exp_otp(2)));
        rd_chk("R11 id masked", 7'h7F, 8'h00);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule